// File: doc/BRIEF.md
# Output Data Path Configuration Unit

This block sits between a host-written configuration byte and the output side of a 16-bit parallel device port. In streaming mode it takes 32-bit words from an upstream source with a valid/ready handshake. It splits each word into two 16-bit device beats and presents them on consecutive clock cycles. On the way out it can reorder the data in three independent ways: which half-word goes first, whether the two bytes of a half-word are exchanged, and whether the bits inside each byte are mirrored.

In programmed mode the host assembles one 16-bit device word from two byte writes, low byte first. Writing the high byte launches a single data-valid strobe that starts at the falling edge of the clock, so the device can latch a word that is already stable. A stop control, either the device's not-ready input or a software bit, halts streaming without losing a half-word that is still pending. An optional start-up delay holds off the first beat of a new burst by one idle cycle.

Top module: `odp_cfg_unit`

## Requirements
- R1: After reset, the configuration byte at register address 0x0F reads 0x00 and `dev_valid` is low. A write to 0x0F stores all 8 bits, and a read of 0x0F returns them. Reads of unmapped addresses return 0x00.
- R2: Configuration bit 3 selects half-word order. When it is clear, the first beat comes from input bits 15..0 and the second from bits 31..16. When it is set, the order is reversed.
- R3: Configuration bit 0 exchanges the upper and lower byte of each output half-word.
- R4: Configuration bit 2 mirrors the bit order inside each byte of each output half-word. It is applied after half-word selection and byte exchange.
- R5: An accepted input word produces its first beat on the cycle after acceptance and its second beat on the cycle after that, unless a stop intervenes. `in_ready` is low while a second beat is pending.
- R6: With configuration bit 4 clear, a burst that starts from idle waits one cycle with `in_valid` high and `in_ready` low before the word is accepted. With bit 4 set, `in_ready` is high at once.
- R7: While `dev_not_ready` is high or configuration bit 5 is set, `in_ready` is low and no beat is issued. A pending second beat is held and issued once the stop is released.
- R8: Configuration bit 6 selects programmed mode. In this mode `in_ready` is low, and `dev_data` carries the high byte register (address 0x11) over the low byte register (address 0x10). Both registers can be read back.
- R9: In programmed mode, a write to address 0x11 raises `dev_valid` at the next falling clock edge and drops it at the following rising edge, which is half a clock period. A write to 0x10 alone raises no strobe.
- R10: Writes to 0x10 and 0x11 are ignored while bit 6 is clear. The registers keep their old values and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| in_data | input | 32 | Upstream 32-bit data word |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Block accepts the word this cycle |
| dev_not_ready | input | 1 | Device back-pressure |
| dev_data | output | 16 | Device data word |
| dev_valid | output | 1 | Device data-valid strobe |

## Verification
The reordering path is driven with a table of configuration and word pairs. The table covers no reordering, each enable alone, all three enables together, and a second word whose bytes are asymmetric. With these patterns, half-word order, byte exchange and in-byte mirroring each yield a different pair of beats, so a swapped control bit or a wrong field position shows up at once. Directed runs then cover the start-up delay, a stall in the middle of a word, the software stop, and the half-cycle strobe sampled before and after the falling edge. A final run checks that programmed writes are ignored when the mode is off.

// File: rtl/odp_pkg.sv
// Package odp_pkg
// Shared register addresses and configuration bit positions for the output
// data path configuration unit. Assumes an 8-bit register address space.
package odp_pkg;

    localparam int unsigned REG_AW = 8;
    localparam int unsigned REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_CFG    = 8'h0F;
    localparam logic [REG_AW-1:0] ADDR_PIO_LO = 8'h10;
    localparam logic [REG_AW-1:0] ADDR_PIO_HI = 8'h11;

    // Bit positions inside the configuration byte
    localparam int unsigned CB_BSWAP  = 0;
    localparam int unsigned CB_BREV   = 2;
    localparam int unsigned CB_HSWAP  = 3;
    localparam int unsigned CB_DLYDIS = 4;
    localparam int unsigned CB_STOP   = 5;
    localparam int unsigned CB_PIO    = 6;

    // Decoded control view of the configuration byte
    typedef struct packed {
        logic pio_en;
        logic force_stop;
        logic dly_dis;
        logic hswap;
        logic brev;
        logic bswap;
    } odp_ctrl_t;

endpackage

// File: rtl/odp_cfg_regs.sv
// Module odp_cfg_regs
// Holds the configuration byte and the two programmed-mode byte registers.
// Decodes the control bits and flags a high-byte write that is accepted.
// Assumes single-cycle write strobes and a combinational read.
module odp_cfg_regs
    import odp_pkg::*;
#(
    parameter int unsigned AW = REG_AW,
    parameter int unsigned DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output odp_ctrl_t     ctrl,
    output logic [2*DW-1:0] pio_word,
    output logic          hi_wr_evt
);

    logic [DW-1:0] cfg_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    logic sel_cfg;
    logic sel_lo;
    logic sel_hi;

    assign sel_cfg = (addr == AW'(ADDR_CFG));
    assign sel_lo  = (addr == AW'(ADDR_PIO_LO));
    assign sel_hi  = (addr == AW'(ADDR_PIO_HI));

    // Store the configuration byte on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && sel_cfg)
            cfg_q <= wdata;
    end

    // Store programmed-mode bytes only while the mode is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en && cfg_q[CB_PIO]) begin
            if (sel_lo) lo_q <= wdata;
            if (sel_hi) hi_q <= wdata;
        end
    end

    // Combinational read mux
    always_comb begin
        rdata = '0;
        if (sel_cfg)     rdata = cfg_q;
        else if (sel_lo) rdata = lo_q;
        else if (sel_hi) rdata = hi_q;
    end

    // Decode the control view
    always_comb begin
        ctrl.pio_en     = cfg_q[CB_PIO];
        ctrl.force_stop = cfg_q[CB_STOP];
        ctrl.dly_dis    = cfg_q[CB_DLYDIS];
        ctrl.hswap      = cfg_q[CB_HSWAP];
        ctrl.brev       = cfg_q[CB_BREV];
        ctrl.bswap      = cfg_q[CB_BSWAP];
    end

    assign pio_word  = {hi_q, lo_q};
    assign hi_wr_evt = wr_en && sel_hi && cfg_q[CB_PIO];

    assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_cfg) |=> (cfg_q == $past(wdata)));

    assert_pio_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_q[CB_PIO]) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/odp_reorder.sv
// Module odp_reorder
// Combinational reordering of one wide input word into two output half-words.
// The steps run in this order: half-word selection, byte exchange, then bit
// mirroring inside each byte. Assumes HW is a multiple of LANE and that
// HW is exactly 2*LANE.
module odp_reorder #(
    parameter int unsigned HW   = 16,
    parameter int unsigned LANE = 8
) (
    input  logic [2*HW-1:0] in_word,
    input  logic            hswap,
    input  logic            bswap,
    input  logic            brev,
    output logic [HW-1:0]   first_hw,
    output logic [HW-1:0]   second_hw
);

    localparam int unsigned NLANE = HW / LANE;

    logic [HW-1:0] sel_a, sel_b;
    logic [HW-1:0] bs_a, bs_b;
    logic [HW-1:0] rv_a, rv_b;

    // Pick which half leaves first
    always_comb begin
        sel_a = hswap ? in_word[2*HW-1:HW] : in_word[HW-1:0];
        sel_b = hswap ? in_word[HW-1:0]    : in_word[2*HW-1:HW];
    end

    // Exchange the two bytes of each half-word
    always_comb begin
        bs_a = bswap ? {sel_a[LANE-1:0], sel_a[HW-1:LANE]} : sel_a;
        bs_b = bswap ? {sel_b[LANE-1:0], sel_b[HW-1:LANE]} : sel_b;
    end

    // Mirror the bits inside every byte lane
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        for (genvar k = 0; k < LANE; k++) begin : g_bit
            assign rv_a[g*LANE+k] = bs_a[g*LANE+(LANE-1-k)];
            assign rv_b[g*LANE+k] = bs_b[g*LANE+(LANE-1-k)];
        end
    end

    assign first_hw  = brev ? rv_a : bs_a;
    assign second_hw = brev ? rv_b : bs_b;

endmodule

// File: rtl/odp_stream_ser.sv
// Module odp_stream_ser
// Two-beat serializer: each accepted word gives two half-word beats on
// consecutive cycles. It stalls on stop, and it can insert one idle cycle
// before the first beat of a burst that starts from idle. Assumes the beat
// data is already reordered.
module odp_stream_ser #(
    parameter int unsigned HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] first_hw,
    input  logic [HW-1:0] second_hw,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          stop,
    input  logic          dly_dis,
    output logic [HW-1:0] beat_data,
    output logic          beat_valid
);

    logic [HW-1:0] hold_q;
    logic [HW-1:0] beat_q;
    logic          have_q;
    logic          valid_q;
    logic          stream_q;
    logic          warm_q;
    logic          accept;

    assign in_ready = !stop && !have_q && (dly_dis || stream_q || warm_q);
    assign accept   = in_valid && in_ready;

    // Beat sequencing: a held second half first, then a new word, else idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            beat_q   <= '0;
            have_q   <= 1'b0;
            valid_q  <= 1'b0;
            stream_q <= 1'b0;
            warm_q   <= 1'b0;
        end else if (stop) begin
            valid_q <= 1'b0;
        end else if (have_q) begin
            beat_q   <= hold_q;
            valid_q  <= 1'b1;
            have_q   <= 1'b0;
            stream_q <= 1'b1;
            warm_q   <= 1'b0;
        end else if (accept) begin
            beat_q   <= first_hw;
            hold_q   <= second_hw;
            have_q   <= 1'b1;
            valid_q  <= 1'b1;
            stream_q <= 1'b1;
            warm_q   <= 1'b0;
        end else begin
            valid_q  <= 1'b0;
            stream_q <= 1'b0;
            warm_q   <= in_valid && !dly_dis;
        end
    end

    assign beat_data  = beat_q;
    assign beat_valid = valid_q;

    assert_accept_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (beat_valid && have_q));

    assert_second_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && !stop) |=> (beat_valid && !have_q));

    assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!beat_valid && $stable(hold_q)));

    assert_start_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly_dis && !stream_q && !warm_q && !have_q) |=> !beat_valid);

endmodule

// File: rtl/odp_pio_strobe.sv
// Module odp_pio_strobe
// Makes a half-period strobe from a one-cycle request. The request is
// registered on the rising edge and copied on the falling edge. The strobe
// is their AND, so it is high from the falling edge to the next rising edge.
// Assumes a clock with a 50% duty cycle.
module odp_pio_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    output logic strobe
);

    logic fire_q;
    logic fall_q;

    // Register the request for one full cycle
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= fire_req;
    end

    // Copy the request onto the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= fire_q;
    end

    assign strobe = fire_q && fall_q;

    assert_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_req |=> fire_q);

    assert_fire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_q && !fire_req) |=> !fire_q);

endmodule

// File: rtl/odp_cfg_unit.sv
// Module odp_cfg_unit (top)
// Output data path configuration unit. It holds the register block, the
// reordering logic, the two-beat serializer and the programmed-mode strobe.
// The programmed mode takes over the device outputs and blocks streaming.
// Assumes one clock domain and a synchronous active-low reset.
module odp_cfg_unit
    import odp_pkg::*;
#(
    parameter int unsigned HW   = 16,
    parameter int unsigned LANE = 8,
    parameter int unsigned AW   = REG_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_en,
    input  logic [AW-1:0]   reg_addr,
    input  logic [LANE-1:0] reg_wdata,
    output logic [LANE-1:0] reg_rdata,
    input  logic [2*HW-1:0] in_data,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            dev_not_ready,
    output logic [HW-1:0]   dev_data,
    output logic            dev_valid
);

    odp_ctrl_t       ctrl;
    logic [HW-1:0]   pio_word;
    logic            hi_wr_evt;
    logic [HW-1:0]   first_hw, second_hw;
    logic [HW-1:0]   beat_data;
    logic            beat_valid;
    logic            ser_stop;
    logic            strobe;

    odp_cfg_regs #(.AW(AW), .DW(LANE)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ctrl      (ctrl),
        .pio_word  (pio_word),
        .hi_wr_evt (hi_wr_evt)
    );

    odp_reorder #(.HW(HW), .LANE(LANE)) i_reorder (
        .in_word   (in_data),
        .hswap     (ctrl.hswap),
        .bswap     (ctrl.bswap),
        .brev      (ctrl.brev),
        .first_hw  (first_hw),
        .second_hw (second_hw)
    );

    // Any stop source, plus programmed mode, freezes the serializer
    assign ser_stop = dev_not_ready || ctrl.force_stop || ctrl.pio_en;

    odp_stream_ser #(.HW(HW)) i_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_hw   (first_hw),
        .second_hw  (second_hw),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .stop       (ser_stop),
        .dly_dis    (ctrl.dly_dis),
        .beat_data  (beat_data),
        .beat_valid (beat_valid)
    );

    odp_pio_strobe i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_req (hi_wr_evt),
        .strobe   (strobe)
    );

    // Device output mux: programmed mode owns the port when enabled
    always_comb begin
        if (ctrl.pio_en) begin
            dev_data  = pio_word;
            dev_valid = strobe;
        end else begin
            dev_data  = beat_data;
            dev_valid = beat_valid;
        end
    end

    assert_pio_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pio_en |-> !in_ready);

endmodule

// File: tb/test_odp_cfg_unit.sv
module test_odp_cfg_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [7:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [31:0] in_data;
    logic        in_valid;
    logic        in_ready;
    logic        dev_not_ready;
    logic [15:0] dev_data;
    logic        dev_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    odp_cfg_unit i_odp_cfg_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .dev_not_ready(dev_not_ready),
        .dev_data(dev_data), .dev_valid(dev_valid)
    );

    // cfg, input word, expected first beat, expected second beat, tag
    typedef struct packed {
        logic [7:0]  cfg;
        logic [31:0] word;
        logic [15:0] b1;
        logic [15:0] b2;
        logic [15:0] tag;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h10, 32'h12345678, 16'h5678, 16'h1234, "R5"},
        '{8'h18, 32'h12345678, 16'h1234, 16'h5678, "R2"},
        '{8'h11, 32'h12345678, 16'h7856, 16'h3412, "R3"},
        '{8'h14, 32'h12345678, 16'h6A1E, 16'h482C, "R4"},
        '{8'h1D, 32'h12345678, 16'h2C48, 16'h1E6A, "R4"},
        '{8'h15, 32'h80010F00, 16'h00F0, 16'h8001, "R3"}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        in_data = '0; in_valid = 1'b0; dev_not_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and register access
        chk("R1 reset dev_valid", {31'h0, dev_valid}, 32'h0);
        rd_chk("R1 reset cfg", 8'h0F, 8'h00);
        @(negedge clk);
        wr(8'h0F, 8'hA5);
        rd_chk("R1 cfg readback", 8'h0F, 8'hA5);
        rd_chk("R1 unmapped", 8'h33, 8'h00);
        @(negedge clk);

        // Table walk of reordering modes (delay disabled)
        foreach (VECS[i]) begin
            wr(8'h0F, VECS[i].cfg);
            in_data = VECS[i].word; in_valid = 1'b1;
            #1;
            chk({"R6 ready ", string'(VECS[i].tag)}, {31'h0, in_ready}, 32'h1);
            @(negedge clk); #1;
            in_valid = 1'b0;
            chk({"beat1 ", string'(VECS[i].tag)}, {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, VECS[i].b1});
            @(negedge clk); #1;
            chk({"R5 beat2 ", string'(VECS[i].tag)}, {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, VECS[i].b2});
            @(negedge clk); #1;
            chk("R5 idle after word", {31'h0, dev_valid}, 32'h0);
            @(negedge clk);
        end

        // R6: start-up delay when bit 4 clear
        wr(8'h0F, 8'h00);
        in_data = 32'h12345678; in_valid = 1'b1;
        #1;
        chk("R6 ready held low", {31'h0, in_ready}, 32'h0);
        @(negedge clk); #1;
        chk("R6 idle cycle valid", {31'h0, dev_valid}, 32'h0);
        chk("R6 ready after idle", {31'h0, in_ready}, 32'h1);
        @(negedge clk); #1;
        in_valid = 1'b0;
        chk("R6 first beat", {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, 16'h5678});
        @(negedge clk); #1;
        chk("R6 second beat", {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, 16'h1234});
        @(negedge clk); @(negedge clk);

        // R7: device not ready stalls, including mid-word
        wr(8'h0F, 8'h10);
        dev_not_ready = 1'b1; in_data = 32'hCAFEBEEF; in_valid = 1'b1;
        #1;
        chk("R7 ready low on dnr", {31'h0, in_ready}, 32'h0);
        @(negedge clk); #1;
        chk("R7 no beat on dnr", {31'h0, dev_valid}, 32'h0);
        dev_not_ready = 1'b0;
        @(negedge clk); #1;
        in_valid = 1'b0;
        chk("R7 beat1 after release", {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, 16'hBEEF});
        dev_not_ready = 1'b1;
        @(negedge clk); #1;
        chk("R7 mid-word hold", {31'h0, dev_valid}, 32'h0);
        dev_not_ready = 1'b0;
        @(negedge clk); #1;
        chk("R7 held beat2", {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, 16'hCAFE});
        @(negedge clk); @(negedge clk);

        // R7: software stop bit 5
        wr(8'h0F, 8'h30);
        in_valid = 1'b1;
        #1;
        chk("R7 sw stop ready", {31'h0, in_ready}, 32'h0);
        @(negedge clk); #1;
        chk("R7 sw stop no beat", {31'h0, dev_valid}, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);

        // R8/R9: programmed mode
        wr(8'h0F, 8'h50);
        in_valid = 1'b1;
        #1;
        chk("R8 ready low in pio", {31'h0, in_ready}, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        wr(8'h10, 8'hCD);
        #2;
        chk("R9 no strobe on low write", {31'h0, dev_valid}, 32'h0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h11; reg_wdata = 8'hAB;
        @(posedge clk); #2;
        chk("R9 low before falling edge", {31'h0, dev_valid}, 32'h0);
        reg_wr_en = 1'b0;
        #5;
        chk("R9 strobe after falling edge", {15'h0, dev_valid, dev_data}, {15'h0, 1'b1, 16'hABCD});
        @(posedge clk); #2;
        chk("R9 strobe ends at rising edge", {31'h0, dev_valid}, 32'h0);
        @(negedge clk);
        rd_chk("R8 low byte readback", 8'h10, 8'hCD);
        rd_chk("R8 high byte readback", 8'h11, 8'hAB);
        @(negedge clk);

        // R10: programmed writes ignored when mode off
        wr(8'h0F, 8'h10);
        reg_wr_en = 1'b1; reg_addr = 8'h11; reg_wdata = 8'hEE;
        @(posedge clk); #7;
        reg_wr_en = 1'b0;
        chk("R10 no strobe when off", {31'h0, dev_valid}, 32'h0);
        @(negedge clk);
        wr(8'h10, 8'h11);
        rd_chk("R10 high byte kept", 8'h11, 8'hAB);
        rd_chk("R10 low byte kept", 8'h10, 8'hCD);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule